// File: doc/BRIEF.md
# Load-Use Interlock Unit

This unit is the interlock for a five-stage in-order pipeline. A load only has its data at the end of the memory stage. An instruction that directly follows a load and reads the loaded register therefore cannot receive that operand by bypassing in time for its execute stage. The unit watches the decode-stage source register numbers, checks them against the load that sits in the execute stage, and inserts exactly one bubble when a true dependence exists.

During the bubble the unit freezes the program counter and the fetch/decode register, so fetch holds its instruction and the younger instructions wait one cycle. It also tells the decode/execute register to load a no-op. The no-op writes no register and does not touch memory. After the bubble, the dependent instruction moves on and takes the loaded value through ordinary bypassing. An instruction two or more slots behind the load never stalls.

The unit keeps its own copy of the hazard-relevant execute-stage fields: the memory-read flag and the destination register. Each cycle these fields take the fields of the instruction leaving decode, or zero when a bubble is inserted. Because of this, the cycle after a bubble cannot trigger a second stall. The unit has no data path of its own. Every pin is a plain control signal with no handshake, and the unit never applies back-pressure except through the two write enables.

Top module: `load_use_interlock`

## Requirements
- R1: A stall is raised in a cycle when the execute-stage memory-read flag is 1, the execute-stage destination is nonzero, and it equals the first decode source register `id_src_a`.
- R2: A stall is raised under the same conditions when the destination equals the second decode source register `id_src_b`, whatever `id_src_a` holds.
- R3: Register number 0 never causes a stall, even for a load whose destination is 0 and whose sources are 0.
- R4: A producer in execute whose memory-read flag is 0 never causes a stall, even when its destination matches a source.
- R5: In a stall cycle `pc_wr_en`=0, `fd_wr_en`=0 and `dx_bubble`=1. In every other cycle after reset, `pc_wr_en`=1, `fd_wr_en`=1 and `dx_bubble`=0.
- R6: On the clock edge that ends a stall cycle, the execute-stage fields become `ex_mem_rd`=0 and `ex_dst`=0. The next cycle therefore has no stall, so each load-use pair costs exactly one bubble.
- R7: On any clock edge that ends a cycle without a stall, `ex_mem_rd` and `ex_dst` take the values of `id_mem_rd` and `id_dst` from that cycle.
- R8: While `rst_n` is 0, and just after it rises, `ex_mem_rd`=0, `ex_dst`=0 and no stall is raised.
- R9: A load followed by one independent instruction and then a reader of the load's destination produces no stall at any point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_mem_rd | input | 1 | Instruction in decode is a load |
| id_dst | input | REG_W | Destination register of the instruction in decode |
| id_src_a | input | REG_W | First source register of the instruction in decode |
| id_src_b | input | REG_W | Second source register of the instruction in decode |
| pc_wr_en | output | 1 | Program counter update enable (0 holds the PC) |
| fd_wr_en | output | 1 | Fetch/decode register write enable (0 holds it) |
| dx_bubble | output | 1 | Load a no-op into the decode/execute register |
| ex_mem_rd | output | 1 | Memory-read flag of the instruction now in execute |
| ex_dst | output | REG_W | Destination register of the instruction now in execute |

## Verification
Directed sequences cover several cases. A load followed at once by a reader through either source port must give one bubble and then free flow. A non-load producer, a register-0 load and a distance-two reader must each give none. A reader right after a bubble checks that the bubble cleared the execute-stage fields instead of letting the stall repeat. Random instruction streams with a narrow register range then produce many matching and non-matching pairs. These streams check that only the full conjunction of load flag, nonzero destination and a source match stalls, and that the execute-stage fields track decode otherwise.

// File: rtl/lui_pkg.sv
package lui_pkg;
  parameter int REG_W = 5;
  localparam int NUM_SRC = 2;
  typedef logic [REG_W-1:0] reg_idx_t;
  typedef struct packed {
    logic     mem_rd;
    reg_idx_t dst;
  } ex_fields_t;
  localparam ex_fields_t EX_NOP = '{mem_rd: 1'b0, dst: '0};
endpackage

// File: rtl/lui_src_match.sv
module lui_src_match #(
  parameter int REG_W = 5
) (
  input  logic             ld_active,
  input  logic [REG_W-1:0] ld_dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  logic dst_nonzero;
  assign dst_nonzero = |ld_dst;
  assign hit = ld_active && dst_nonzero && (ld_dst == src);
endmodule

// File: rtl/lui_ex_shadow.sv
module lui_ex_shadow
  import lui_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insert_nop,
  input  ex_fields_t from_id,
  output ex_fields_t in_ex
);
  always_ff @(posedge clk) begin
    if (!rst_n)          in_ex <= EX_NOP;
    else if (insert_nop) in_ex <= EX_NOP;
    else                 in_ex <= from_id;
  end
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import lui_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_mem_rd,
  input  logic [REG_W-1:0] id_dst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  output logic             pc_wr_en,
  output logic             fd_wr_en,
  output logic             dx_bubble,
  output logic             ex_mem_rd,
  output logic [REG_W-1:0] ex_dst
);
  ex_fields_t       id_f, ex_f;
  reg_idx_t         srcs [NUM_SRC];
  logic [NUM_SRC-1:0] hits;
  logic             stall;

  assign id_f.mem_rd = id_mem_rd;
  assign id_f.dst    = id_dst;
  assign srcs[0]     = id_src_a;
  assign srcs[1]     = id_src_b;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    lui_src_match #(.REG_W(REG_W)) u_match (
      .ld_active (ex_f.mem_rd),
      .ld_dst    (ex_f.dst),
      .src       (srcs[s]),
      .hit       (hits[s])
    );
  end

  assign stall = rst_n && (|hits);

  lui_ex_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .insert_nop (stall),
    .from_id    (id_f),
    .in_ex      (ex_f)
  );

  assign pc_wr_en  = !stall;
  assign fd_wr_en  = !stall;
  assign dx_bubble = stall;
  assign ex_mem_rd = ex_f.mem_rd;
  assign ex_dst    = ex_f.dst;
endmodule

// File: rtl/load_use_interlock_chk.sv
module load_use_interlock_chk
  import lui_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             id_mem_rd,
  input logic [REG_W-1:0] id_dst,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             pc_wr_en,
  input logic             fd_wr_en,
  input logic             dx_bubble,
  input logic             ex_mem_rd,
  input logic [REG_W-1:0] ex_dst
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  // R1
  rs1_load_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_rd && ex_dst != '0 && ex_dst == id_src_a) |-> dx_bubble);
  // R2
  rs2_load_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_rd && ex_dst != '0 && ex_dst == id_src_b) |-> dx_bubble);
  // R3
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> !dx_bubble);
  // R4
  non_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_rd |-> !dx_bubble);
  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dx_bubble |-> (!pc_wr_en && !fd_wr_en));
  // R6
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dx_bubble |=> (!dx_bubble && !ex_mem_rd && ex_dst == '0));
  // R7
  shadow_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !dx_bubble) |=> (ex_mem_rd == $past(id_mem_rd) && ex_dst == $past(id_dst)));
endmodule

bind load_use_interlock load_use_interlock_chk u_chk (.*);

// File: tb/load_use_interlock_tb.sv
module load_use_interlock_tb;
  import lui_pkg::*;
  logic clk = 0, rst_n = 0;
  logic id_mem_rd = 0;
  reg_idx_t id_dst = '0, id_src_a = '0, id_src_b = '0;
  logic pc_wr_en, fd_wr_en, dx_bubble, ex_mem_rd;
  reg_idx_t ex_dst;
  int checks = 0, fails = 0, cyc = 0;
  logic m_mr = 0; reg_idx_t m_dst = '0;
  bit done = 0;

  always #2 clk = ~clk;

  load_use_interlock u_dut (.*);

  function automatic logic exp_stall(logic mr, reg_idx_t d, reg_idx_t a, reg_idx_t b);
    return mr && (d != '0) && (d == a || d == b);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // drive one decode slot, check outputs mid-cycle, advance model at the edge
  task automatic step(string tag, logic mr, reg_idx_t d, reg_idx_t a, reg_idx_t b);
    logic es;
    @(negedge clk);
    id_mem_rd = mr; id_dst = d; id_src_a = a; id_src_b = b;
    #1;
    es = exp_stall(m_mr, m_dst, a, b);
    chk({tag, " bubble"}, 8'(dx_bubble), 8'(es));
    chk({tag, " pc_we R5"}, 8'(pc_wr_en), 8'(!es));
    chk({tag, " fd_we R5"}, 8'(fd_wr_en), 8'(!es));
    chk({tag, " ex_mr R7"}, 8'(ex_mem_rd), 8'(m_mr));
    chk({tag, " ex_dst R7"}, 8'(ex_dst), 8'(m_dst));
    @(posedge clk);
    cyc++;
    if (es) begin m_mr = 0; m_dst = '0; end
    else begin m_mr = mr; m_dst = d; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 ex_mr", 8'(ex_mem_rd), 8'd0);
    chk("R8 ex_dst", 8'(ex_dst), 8'd0);
    chk("R8 bubble", 8'(dx_bubble), 8'd0);
    rst_n = 1;
    #1 chk("R8 pc_we", 8'(pc_wr_en), 8'd1);

    // R1 dependent via first source: one bubble then flow (R6)
    step("R1 load", 1, 5'd1, 5'd2, 5'd3);
    step("R1 use", 0, 5'd4, 5'd1, 5'd3);
    step("R6 retry", 0, 5'd4, 5'd1, 5'd3);
    // R2 dependent via second source
    step("R2 load", 1, 5'd7, 5'd2, 5'd0);
    step("R2 use", 0, 5'd8, 5'd3, 5'd7);
    step("R6 retry2", 0, 5'd8, 5'd3, 5'd7);
    // R4 non-load producer
    step("R4 alu", 0, 5'd9, 5'd2, 5'd3);
    step("R4 use", 0, 5'd10, 5'd9, 5'd9);
    // R3 load to register zero
    step("R3 load0", 1, 5'd0, 5'd0, 5'd0);
    step("R3 use0", 0, 5'd11, 5'd0, 5'd0);
    // independent pair
    step("R1 indep load", 1, 5'd12, 5'd1, 5'd2);
    step("R1 indep use", 0, 5'd13, 5'd14, 5'd15);
    // R9 distance two
    step("R9 load", 1, 5'd6, 5'd1, 5'd2);
    step("R9 gap", 0, 5'd16, 5'd17, 5'd18);
    step("R9 use", 0, 5'd19, 5'd6, 5'd6);
    // back-to-back loads, second depends on first
    step("R6 ld a", 1, 5'd3, 5'd1, 5'd2);
    step("R6 ld b", 1, 5'd5, 5'd3, 5'd0);
    step("R6 ld b2", 1, 5'd5, 5'd3, 5'd0);
    step("R6 use b", 0, 5'd20, 5'd0, 5'd5);
    step("R6 use b2", 0, 5'd20, 5'd0, 5'd5);

    // random streams over a narrow register range
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      step("R1R2 rand", 1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
           5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule